// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block holds the exception state of a simple pipelined 32-bit processor. It keeps a small stack of mode and interrupt-enable bit pairs: the current pair, the previous one and an older one. When the pipeline raises an exception, the stack is pushed and the current pair becomes kernel mode with interrupts off. A return-from-exception strobe pops the stack. The pipeline also has a status write path that loads the whole stack directly.

On exception entry, the block records the restart address. If the faulting instruction sits in a branch delay slot, it flags that in a cause bit and points the restart address back at the branch. In the same edge it raises a one-cycle redirect toward a fixed handler vector. Instruction decode, TLB handling and choice among several vectors are left to other logic.

Top module: `exc_unit`

## Requirements
- R1: While reset is low, and after it is released with no other input, every bit of `kuStack` and `ieStack` is 0, `epcOut` is 0, `causeBd` is 0, `redirValid` is 0 and `redirAddr` is 0.
- R2: Stack bit encoding: index 0 is the current pair, index 1 the previous pair and index 2 the old pair. A `kuStack` bit of 0 means kernel and 1 means user. An `ieStack` bit of 1 means interrupts are enabled. On an edge where `excReq` is 1, each level i>0 takes the value of level i-1, and level 0 becomes 0 in both vectors.
- R3: On an edge where `excReq` is 1 and `excInSlot` is 0, `epcOut` becomes `excPc` and `causeBd` becomes 0.
- R4: On an edge where `excReq` is 1 and `excInSlot` is 1, `epcOut` becomes `excPc` minus 4, modulo 2^32, and `causeBd` becomes 1.
- R5: On an edge where `retStrobe` is 1 and `excReq` is 0, each level i below the top takes the value of level i+1. The top level keeps its value. `epcOut` and `causeBd` do not change.
- R6: When `excReq` and `retStrobe` are both 1 on the same edge, the block behaves exactly as R2 to R4 describe, and the return has no effect.
- R7: `redirValid` is 1 for exactly the cycle after each edge on which `excReq` was 1, and 0 otherwise. `redirAddr` equals 32'h8000_0080 while `redirValid` is 1 and is 0 otherwise.
- R8: On an edge where `stWrEn` is 1 and neither `excReq` nor `retStrobe` is 1, the stack takes `stWrKu` and `stWrIe`. When either of those two is 1, the write is ignored.
- R9: On an edge where none of `excReq`, `retStrobe` or `stWrEn` is 1, the stack, `epcOut` and `causeBd` all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Exception request from the pipeline |
| excPc | input | 32 | Address of the faulting instruction |
| excInSlot | input | 1 | Faulting instruction is in a branch delay slot |
| retStrobe | input | 1 | Return-from-exception strobe |
| stWrEn | input | 1 | Status stack write enable |
| stWrKu | input | 3 | Mode bits to load, index 0 is current |
| stWrIe | input | 3 | Interrupt-enable bits to load, index 0 is current |
| kuStack | output | 3 | Mode bits: current, previous, old |
| ieStack | output | 3 | Interrupt-enable bits: current, previous, old |
| epcOut | output | 32 | Restart address of the last exception |
| causeBd | output | 1 | Last exception was taken in a delay slot |
| redirValid | output | 1 | One-cycle fetch redirect to the handler |
| redirAddr | output | 32 | Handler vector while redirecting |

## Verification
The assertions assume that the delay-slot flag belongs to the instruction presented with the request. They also assume that a faulting instruction in a slot is never at address 0, because in that case the restart address wraps. The stimulus meets the first assumption by changing all inputs at falling edges only. It steps outside the second assumption on purpose, in one directed case that checks the wrap value at the ports. The sweep covers every one of the 64 stack patterns. For each pattern it applies entry, return, idle, combined entry and return, and writes that collide with entry or return.

// File: rtl/exc_unit_pkg.sv
package exc_unit_pkg;
  // Strobes from control to datapath; at most one is high in a cycle.
  typedef struct packed {
    logic push;
    logic pop;
    logic load;
  } stackOpT;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_unit_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    excReq,
  input  logic    retStrobe,
  input  logic    stWrEn,
  output stackOpT op,
  output logic    redirValid
);
  // Priority: exception, then return, then status write.
  always_comb begin
    op.push = excReq;
    op.pop  = retStrobe && !excReq;
    op.load = stWrEn && !excReq && !retStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) redirValid <= 1'b0;
    else       redirValid <= excReq;
  end
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_unit_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DEPTH       = 3,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackOpT           op,
  input  logic [ADDR_W-1:0] excPc,
  input  logic              excInSlot,
  input  logic [DEPTH-1:0]  wrKu,
  input  logic [DEPTH-1:0]  wrIe,
  output logic [DEPTH-1:0]  kuStack,
  output logic [DEPTH-1:0]  ieStack,
  output logic [ADDR_W-1:0] epc,
  output logic              bd
);
  localparam logic [ADDR_W-1:0] SLOT_BACK = ADDR_W'(INSTR_BYTES);

  logic [DEPTH-1:0] pushKu, pushIe, popKu, popIe;

  for (genvar lvl = 0; lvl < DEPTH; lvl++) begin : g_lvl
    if (lvl == 0) begin : g_bottom
      assign pushKu[lvl] = 1'b0;
      assign pushIe[lvl] = 1'b0;
    end else begin : g_shiftUp
      assign pushKu[lvl] = kuStack[lvl-1];
      assign pushIe[lvl] = ieStack[lvl-1];
    end
    if (lvl == DEPTH - 1) begin : g_top
      assign popKu[lvl] = kuStack[lvl];
      assign popIe[lvl] = ieStack[lvl];
    end else begin : g_shiftDown
      assign popKu[lvl] = kuStack[lvl+1];
      assign popIe[lvl] = ieStack[lvl+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kuStack <= '0;
      ieStack <= '0;
    end else if (op.push) begin
      kuStack <= pushKu;
      ieStack <= pushIe;
    end else if (op.pop) begin
      kuStack <= popKu;
      ieStack <= popIe;
    end else if (op.load) begin
      kuStack <= wrKu;
      ieStack <= wrIe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epc <= '0;
      bd  <= 1'b0;
    end else if (op.push) begin
      epc <= excInSlot ? (excPc - SLOT_BACK) : excPc;
      bd  <= excInSlot;
    end
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_unit_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                DEPTH       = 3,
  parameter int                INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] HANDLER_VEC = 32'h8000_0080
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [ADDR_W-1:0] excPc,
  input  logic              excInSlot,
  input  logic              retStrobe,
  input  logic              stWrEn,
  input  logic [DEPTH-1:0]  stWrKu,
  input  logic [DEPTH-1:0]  stWrIe,
  output logic [DEPTH-1:0]  kuStack,
  output logic [DEPTH-1:0]  ieStack,
  output logic [ADDR_W-1:0] epcOut,
  output logic              causeBd,
  output logic              redirValid,
  output logic [ADDR_W-1:0] redirAddr
);
  stackOpT op;

  exc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .retStrobe(retStrobe),
    .stWrEn(stWrEn), .op(op), .redirValid(redirValid)
  );

  exc_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .INSTR_BYTES(INSTR_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .op(op), .excPc(excPc), .excInSlot(excInSlot),
    .wrKu(stWrKu), .wrIe(stWrIe), .kuStack(kuStack), .ieStack(ieStack),
    .epc(epcOut), .bd(causeBd)
  );

  assign redirAddr = redirValid ? HANDLER_VEC : '0;
endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk #(
  parameter int                ADDR_W      = 32,
  parameter int                DEPTH       = 3,
  parameter int                INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] HANDLER_VEC = 32'h8000_0080
) (
  input logic              clk,
  input logic              rstN,
  input logic              excReq,
  input logic [ADDR_W-1:0] excPc,
  input logic              excInSlot,
  input logic              retStrobe,
  input logic              stWrEn,
  input logic [DEPTH-1:0]  stWrKu,
  input logic [DEPTH-1:0]  stWrIe,
  input logic [DEPTH-1:0]  kuStack,
  input logic [DEPTH-1:0]  ieStack,
  input logic [ADDR_W-1:0] epcOut,
  input logic              causeBd,
  input logic              redirValid,
  input logic [ADDR_W-1:0] redirAddr
);
  localparam logic [ADDR_W-1:0] SLOT_BACK = ADDR_W'(INSTR_BYTES);

  a_r2_entry_kernel: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (kuStack[0] == 1'b0) && (ieStack[0] == 1'b0));

  a_r2_entry_shift: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (kuStack[DEPTH-1:1] == $past(kuStack[DEPTH-2:0]))
            && (ieStack[DEPTH-1:1] == $past(ieStack[DEPTH-2:0])));

  a_r3_epc_plain: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && !excInSlot) |=> (epcOut == $past(excPc)) && !causeBd);

  a_r4_epc_slot: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && excInSlot && (excPc != '0)) |=> (epcOut == $past(excPc) - SLOT_BACK) && causeBd);

  a_r5_return_pop: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !excReq) |=> (kuStack[DEPTH-2:0] == $past(kuStack[DEPTH-1:1]))
            && (ieStack[DEPTH-2:0] == $past(ieStack[DEPTH-1:1]))
            && $stable(kuStack[DEPTH-1]) && $stable(ieStack[DEPTH-1])
            && $stable(epcOut) && $stable(causeBd));

  a_r6_exc_wins: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && retStrobe) |=> (kuStack[0] == 1'b0) && (ieStack[0] == 1'b0) && redirValid);

  a_r7_redirect: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> redirValid && (redirAddr == HANDLER_VEC));

  a_r7_no_redirect: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |=> !redirValid && (redirAddr == '0));

  a_r8_load: assert property (@(posedge clk) disable iff (!rstN)
    (stWrEn && !excReq && !retStrobe) |=> (kuStack == $past(stWrKu)) && (ieStack == $past(stWrIe)));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!excReq && !retStrobe && !stWrEn) |=> $stable(kuStack) && $stable(ieStack)
            && $stable(epcOut) && $stable(causeBd));
endmodule

bind exc_unit exc_unit_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .INSTR_BYTES(INSTR_BYTES), .HANDLER_VEC(HANDLER_VEC)
) u_chk (
  .clk(clk), .rstN(rstN), .excReq(excReq), .excPc(excPc), .excInSlot(excInSlot),
  .retStrobe(retStrobe), .stWrEn(stWrEn), .stWrKu(stWrKu), .stWrIe(stWrIe),
  .kuStack(kuStack), .ieStack(ieStack), .epcOut(epcOut), .causeBd(causeBd),
  .redirValid(redirValid), .redirAddr(redirAddr)
);

// File: tb/sim_exc_unit.sv
module sim_exc_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [31:0] excPc = '0;
  logic        excInSlot = 1'b0;
  logic        retStrobe = 1'b0;
  logic        stWrEn = 1'b0;
  logic [2:0]  stWrKu = '0;
  logic [2:0]  stWrIe = '0;
  logic [2:0]  kuStack, ieStack;
  logic [31:0] epcOut, redirAddr;
  logic        causeBd, redirValid;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Reference state
  logic [2:0]  mKu = '0, mIe = '0;
  logic [31:0] mEpc = '0;
  logic        mBd = 1'b0, mRv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_unit u0 (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excPc(excPc), .excInSlot(excInSlot),
    .retStrobe(retStrobe), .stWrEn(stWrEn), .stWrKu(stWrKu), .stWrIe(stWrIe),
    .kuStack(kuStack), .ieStack(ieStack), .epcOut(epcOut), .causeBd(causeBd),
    .redirValid(redirValid), .redirAddr(redirAddr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string req);
    chk(req, "kuStack", {29'd0, kuStack}, {29'd0, mKu});
    chk(req, "ieStack", {29'd0, ieStack}, {29'd0, mIe});
    chk(req, "epcOut", epcOut, mEpc);
    chk(req, "causeBd", {31'd0, causeBd}, {31'd0, mBd});
    chk(req, "redirValid", {31'd0, redirValid}, {31'd0, mRv});
    chk(req, "redirAddr", redirAddr, mRv ? 32'h8000_0080 : 32'h0);
  endtask

  // Apply one cycle of stimulus (inputs already set at a falling edge), update the model, check.
  task automatic step(input string req);
    if (excReq) begin
      mKu  = {mKu[1:0], 1'b0};
      mIe  = {mIe[1:0], 1'b0};
      mEpc = excInSlot ? excPc - 32'd4 : excPc;
      mBd  = excInSlot;
    end else if (retStrobe) begin
      mKu = {mKu[2], mKu[2:1]};
      mIe = {mIe[2], mIe[2:1]};
    end else if (stWrEn) begin
      mKu = stWrKu;
      mIe = stWrIe;
    end
    mRv = excReq;
    @(posedge clk);
    @(negedge clk);
    excReq = 1'b0; retStrobe = 1'b0; stWrEn = 1'b0; excInSlot = 1'b0;
    chkAll(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    stWrKu = 3'b111; stWrIe = 3'b111;
    repeat (3) @(negedge clk);
    chkAll("R1");                       // during reset
    rstN = 1'b1;
    step("R1");                         // idle after release
    step("R9");

    for (int p = 0; p < 64; p++) begin
      logic [31:0] pc;
      pc = (32'(p) * 32'h0404_0404) & 32'hFFFF_FFFC;
      if (pc == '0) pc = 32'h0000_1000;
      // R8: load a pattern
      stWrEn = 1'b1; stWrKu = p[2:0]; stWrIe = p[5:3];
      step("R8");
      step("R9");
      // R2/R3/R4/R7: entry, alternating slot, with a colliding write (R8 ignored)
      excReq = 1'b1; excPc = pc; excInSlot = p[0] ^ p[3];
      stWrEn = 1'b1; stWrKu = ~p[2:0]; stWrIe = ~p[5:3];
      step(excInSlot ? "R4" : "R3");
      step("R7");                       // redirect drops after one cycle
      // R5: return, with a colliding write
      retStrobe = 1'b1; stWrEn = 1'b1; stWrKu = 3'b101; stWrIe = 3'b010;
      step("R5");
      // R6: entry and return together
      excReq = 1'b1; retStrobe = 1'b1; excPc = pc + 32'd8; excInSlot = p[1];
      step("R6");
      // R5: two returns, reaching the top level
      retStrobe = 1'b1;
      step("R5");
      retStrobe = 1'b1;
      step("R5");
    end

    // R4: delay slot at address 0 wraps
    excReq = 1'b1; excPc = 32'h0; excInSlot = 1'b1;
    step("R4");
    // R7: back-to-back entries keep the redirect high each cycle
    excReq = 1'b1; excPc = 32'hBFC0_0100;
    step("R7");
    excReq = 1'b1; excPc = 32'hBFC0_0200; excInSlot = 1'b1;
    step("R7");
    step("R9");
    // R1: reset again from a nonzero state
    stWrEn = 1'b1; stWrKu = 3'b111; stWrIe = 3'b111;
    step("R8");
    rstN = 1'b0;
    mKu = '0; mIe = '0; mEpc = '0; mBd = 1'b0; mRv = 1'b0;
    @(posedge clk); @(negedge clk);
    chkAll("R1");
    rstN = 1'b1;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule